// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Controller

This block is the front end that turns bus-side strobes into internal word addresses for a pipelined synchronous SRAM with a 32-bit data path. On each rising clock edge it samples an external address, three chip enables, a write control, two address strobes, an advance input, a burst-order select and a sleep request. From these it decides whether a new access starts, whether an ongoing burst steps, or whether nothing happens.

There are two address strobes with different rules. The processor strobe counts only while the gating enable is low, and it always starts a read. The controller strobe counts on its own, and the write control decides whether it starts a read or a write. Either strobe loads a new base address. The device is selected only if all three enables are asserted. After a load, a 2-bit burst counter steps the two low address bits while the advance input is low. The order is either a wrapping count-up or an XOR sequence over the starting low bits, fixed by the order select sampled at load time.

All outputs are registered, so a result shows up after the clock edge on which its inputs were sampled. The memory array, byte-write decoding and output drivers are outside this block.

Top module: `sram_addr_ctrl`

## Requirements
- R1: All outputs change only on a rising clock edge and reflect the inputs sampled at that edge. After reset, `valid_o`, `is_write_o` and `standby_o` are 0 and `word_addr_o` is 0.
- R2: A load selects the device only when `ce_gate_n`=0, `ce_lo_n`=0 and `ce_hi`=1. A load with any enable deasserted still captures the address but leaves the device deselected with `valid_o`=0.
- R3: With `ps_n`=0 and `ce_gate_n`=0, the address is loaded, `word_addr_o` equals `addr_i`, and a read starts (`is_write_o`=0) whatever the value of `wr_n`.
- R4: When `ce_gate_n`=1, `ps_n` has no effect. When both strobes are qualified in the same cycle, the processor strobe wins, so the cycle is a read.
- R5: With `cs_n`=0 and no qualified processor strobe, the address is loaded. The cycle is a write (`is_write_o`=1) when `wr_n`=0 and a read otherwise.
- R6: On a selected device with no strobe, `adv_n`=0 steps the burst with `valid_o`=1. `adv_n`=1 is a wait cycle: the address is held and `valid_o`=0.
- R7: If `burst_mode_i`=0 at load, the low two address bits after k steps are (start + k) mod 4.
- R8: If `burst_mode_i`=1 at load, the low two address bits after k steps are start XOR (k mod 4).
- R9: Bits above bit 1 of `word_addr_o` keep the loaded value during a burst. The burst wraps after four words and keeps cycling.
- R10: A cycle sampled with `snooze_i`=1 gives `standby_o`=1 and `valid_o`=0, deselects the device and starts no cycle. `standby_o` returns to 0 after a cycle sampled with `snooze_i`=0.
- R11: An advance while the device is deselected has no effect: `valid_o`=0 and `word_addr_o` unchanged.
- R12: The synchronous reset `rst`=1 deselects the device and clears the burst counter, and overrides every other input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | External word address |
| ce_gate_n | input | 1 | Active-low enable that also qualifies `ps_n` |
| ce_lo_n | input | 1 | Second active-low enable |
| ce_hi | input | 1 | Active-high enable |
| ps_n | input | 1 | Processor address strobe, active low, read only |
| cs_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high inserts a wait |
| wr_n | input | 1 | Write control, active low, used with `cs_n` |
| burst_mode_i | input | 1 | 0 selects linear order, 1 selects interleaved order |
| snooze_i | input | 1 | Standby request, active high |
| word_addr_o | output | ADDR_W | Internal word address |
| valid_o | output | 1 | An access happens in this cycle |
| is_write_o | output | 1 | Current access is a write |
| standby_o | output | 1 | Device is in standby |

## Verification
The assertions assume every input is a clean 0 or 1 at each rising edge. They also assume `rst` is held for at least one edge before the checks matter. Within that, the strobes, enables, advance, write control and mode may take any value in any cycle. The bench drives all inputs on the falling edge, so they are stable at the sampling edge. It draws them with biased random weights, so that loads, bursts of several steps, waits, sleep periods and mid-burst resets all occur. This lets strobe collisions and enables going away in the middle of a burst come up often.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_SNOOZE,
        CMD_LOAD_PS,
        CMD_LOAD_CS,
        CMD_STEP,
        CMD_WAIT
    } cmd_e;

    typedef struct packed {
        logic [BURST_W-1:0] cnt;
        logic               mode;
        logic               sel;
        logic               wr;
        logic               valid;
        logic               stby;
    } ctl_t;

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ce_gate_n,
    input  logic ce_lo_n,
    input  logic ce_hi,
    input  logic ps_n,
    input  logic cs_n,
    input  logic adv_n,
    input  logic snooze_i,
    input  logic sel_q,
    output cmd_e cmd,
    output logic enables_ok
);

    logic ps_qual;

    always_comb begin
        ps_qual    = !ps_n && !ce_gate_n;
        enables_ok = !ce_gate_n && !ce_lo_n && ce_hi;
        if (snooze_i) begin
            cmd = CMD_SNOOZE;
        end else if (ps_qual) begin
            cmd = CMD_LOAD_PS;
        end else if (!cs_n) begin
            cmd = CMD_LOAD_CS;
        end else if (sel_q && !adv_n) begin
            cmd = CMD_STEP;
        end else if (sel_q) begin
            cmd = CMD_WAIT;
        end else begin
            cmd = CMD_IDLE;
        end
    end

    AST_GATED_PS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ce_gate_n && ps_n == 1'b0 && cs_n && !snooze_i) |-> (cmd != CMD_LOAD_PS && cmd != CMD_LOAD_CS)) // R4
        else $error("gated processor strobe started a load");

    AST_PS_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!ps_n && !ce_gate_n && !cs_n && !snooze_i) |-> (cmd == CMD_LOAD_PS)) // R4
        else $error("controller strobe beat processor strobe");

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_ctl_pkg::*;
(
    input  logic [BURST_W-1:0] start,
    input  logic [BURST_W-1:0] cnt,
    input  logic               mode,
    output logic [BURST_W-1:0] low_addr,
    output logic [BURST_W-1:0] cnt_inc
);

    logic [BURST_W-1:0] lin_addr;
    logic [BURST_W-1:0] ilv_addr;

    always_comb begin
        cnt_inc  = cnt + BURST_W'(1);
        lin_addr = start + cnt;
        ilv_addr = start ^ cnt;
        low_addr = mode ? ilv_addr : lin_addr;
    end

endmodule

// File: rtl/sram_addr_ctrl.sv
module sram_addr_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_gate_n,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    input  logic              ps_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              wr_n,
    input  logic              burst_mode_i,
    input  logic              snooze_i,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic              valid_o,
    output logic              is_write_o,
    output logic              standby_o
);

    localparam int UPPER_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        ctl_t              ctl;
    } state_t;

    state_t state_d, state_q;

    cmd_e               cmd;
    logic               enables_ok;
    logic [BURST_W-1:0] low_addr;
    logic [BURST_W-1:0] cnt_inc;

    sram_cmd_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .ce_gate_n  (ce_gate_n),
        .ce_lo_n    (ce_lo_n),
        .ce_hi      (ce_hi),
        .ps_n       (ps_n),
        .cs_n       (cs_n),
        .adv_n      (adv_n),
        .snooze_i   (snooze_i),
        .sel_q      (state_q.ctl.sel),
        .cmd        (cmd),
        .enables_ok (enables_ok)
    );

    sram_burst_seq u_seq (
        .start    (state_q.base[BURST_W-1:0]),
        .cnt      (state_q.ctl.cnt),
        .mode     (state_q.ctl.mode),
        .low_addr (low_addr),
        .cnt_inc  (cnt_inc)
    );

    always_comb begin
        state_d           = state_q;
        state_d.ctl.valid = 1'b0;
        state_d.ctl.stby  = 1'b0;
        unique case (cmd)
            CMD_SNOOZE: begin
                state_d.ctl.stby = 1'b1;
                state_d.ctl.sel  = 1'b0;
            end
            CMD_LOAD_PS: begin
                state_d.base      = addr_i;
                state_d.ctl.cnt   = '0;
                state_d.ctl.mode  = burst_mode_i;
                state_d.ctl.sel   = enables_ok;
                state_d.ctl.wr    = 1'b0;
                state_d.ctl.valid = enables_ok;
            end
            CMD_LOAD_CS: begin
                state_d.base      = addr_i;
                state_d.ctl.cnt   = '0;
                state_d.ctl.mode  = burst_mode_i;
                state_d.ctl.sel   = enables_ok;
                state_d.ctl.wr    = !wr_n;
                state_d.ctl.valid = enables_ok;
            end
            CMD_STEP: begin
                state_d.ctl.cnt   = cnt_inc;
                state_d.ctl.valid = 1'b1;
            end
            CMD_WAIT: begin
                state_d.ctl.valid = 1'b0;
            end
            default: begin
                state_d.ctl.valid = 1'b0;
            end
        endcase
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        word_addr_o = {state_q.base[ADDR_W-1:BURST_W], low_addr};
        valid_o     = state_q.ctl.valid;
        is_write_o  = state_q.ctl.wr;
        standby_o   = state_q.ctl.stby;
    end

    AST_SNOOZE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        snooze_i |=> (standby_o && !valid_o)) // R10
        else $error("cycle issued during standby");

    AST_PS_IS_READ: assert property (@(posedge clk) disable iff (rst)
        (!ps_n && !ce_gate_n && !snooze_i) |=> (!is_write_o && word_addr_o == $past(addr_i))) // R3
        else $error("processor strobe did not start a read");

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q.ctl.sel && !snooze_i && cs_n && (ps_n || ce_gate_n) && adv_n)
        |=> ($stable(word_addr_o) && !valid_o)) // R6
        else $error("wait cycle moved the address");

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (state_q.ctl.sel && !snooze_i && cs_n && (ps_n || ce_gate_n) && !adv_n)
        |=> (valid_o && word_addr_o[ADDR_W-1:BURST_W] == $past(word_addr_o[ADDR_W-1:BURST_W]))) // R9
        else $error("upper address bits changed in a burst");

    AST_DESEL_ADV_NOP: assert property (@(posedge clk) disable iff (rst)
        (!state_q.ctl.sel && !snooze_i && cs_n && (ps_n || ce_gate_n))
        |=> (!valid_o && $stable(word_addr_o))) // R11
        else $error("advance acted while deselected");

    AST_VALID_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        (!snooze_i && !enables_ok && (!cs_n || (!ps_n && !ce_gate_n))) |=> !valid_o) // R2
        else $error("load with missing enable produced a cycle");

    initial begin
        assert (UPPER_W >= 1) else $error("ADDR_W too small"); // R9
    end

endmodule

// File: tb/sram_addr_ctrl_tb.sv
module sram_addr_ctrl_tb;

    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr_i;
    logic              ce_gate_n, ce_lo_n, ce_hi, ps_n, cs_n, adv_n, wr_n;
    logic              burst_mode_i, snooze_i;
    logic [ADDR_W-1:0] word_addr_o;
    logic              valid_o, is_write_o, standby_o;

    always #10 clk = ~clk;

    sram_addr_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .addr_i       (addr_i),
        .ce_gate_n    (ce_gate_n),
        .ce_lo_n      (ce_lo_n),
        .ce_hi        (ce_hi),
        .ps_n         (ps_n),
        .cs_n         (cs_n),
        .adv_n        (adv_n),
        .wr_n         (wr_n),
        .burst_mode_i (burst_mode_i),
        .snooze_i     (snooze_i),
        .word_addr_o  (word_addr_o),
        .valid_o      (valid_o),
        .is_write_o   (is_write_o),
        .standby_o    (standby_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [ADDR_W-1:0] m_base;
    logic [1:0]        m_cnt;
    logic              m_mode, m_sel, m_wr, m_valid, m_stby;
    string             m_tag;

    function automatic logic [ADDR_W-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[ADDR_W-1:2], lo};
    endfunction

    task automatic model_step();
        logic en;
        en = !ce_gate_n && !ce_lo_n && ce_hi;
        m_valid = 1'b0;
        m_stby  = 1'b0;
        if (rst) begin
            m_base = '0; m_cnt = '0; m_mode = 0; m_sel = 0; m_wr = 0;
            m_tag = "R12";
        end else if (snooze_i) begin
            m_stby = 1'b1; m_sel = 1'b0; m_tag = "R10";
        end else if (!ps_n && !ce_gate_n) begin
            m_base = addr_i; m_cnt = 0; m_mode = burst_mode_i;
            m_sel = en; m_wr = 0; m_valid = en; m_tag = "R3";
        end else if (!cs_n) begin
            m_base = addr_i; m_cnt = 0; m_mode = burst_mode_i;
            m_sel = en; m_wr = !wr_n; m_valid = en; m_tag = "R5";
        end else if (m_sel && !adv_n) begin
            m_cnt = m_cnt + 2'd1; m_valid = 1'b1;
            m_tag = m_mode ? "R8" : "R7";
        end else if (m_sel) begin
            m_tag = "R6";
        end else begin
            m_tag = "R11";
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, 64'(word_addr_o), 64'(exp_addr()), "word_addr_o");
        chk(req, 64'(valid_o), 64'(m_valid), "valid_o");
        chk(req, 64'(is_write_o), 64'(m_wr), "is_write_o");
        chk(req, 64'(standby_o), 64'(m_stby), "standby_o");
    endtask

    // inputs already set (after negedge); model, clock, check at next negedge
    task automatic cycle(input string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(req.len() > 0 ? req : m_tag);
    endtask

    task automatic idle_in();
        rst = 0; addr_i = '0; ce_gate_n = 1; ce_lo_n = 0; ce_hi = 1;
        ps_n = 1; cs_n = 1; adv_n = 1; wr_n = 1; burst_mode_i = 0; snooze_i = 0;
    endtask

    task automatic load(input bit use_ps, input logic [ADDR_W-1:0] a, input logic md, input logic w_n, input string req);
        idle_in();
        ce_gate_n = 0; addr_i = a; burst_mode_i = md; wr_n = w_n;
        if (use_ps) ps_n = 0; else cs_n = 0;
        cycle(req);
    endtask

    task automatic adv(input string req);
        idle_in(); adv_n = 0; cycle(req);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_in();
        rst = 1;
        @(negedge clk);
        cycle("R1");
        cycle("R12");

        // R3: processor strobe reads even with write asserted
        load(1, 18'h2A5C1, 0, 0, "R3");
        chk("R3", 64'(word_addr_o), 64'h2A5C1, "loaded address");
        // R7: linear from 01 -> 10,11,00,01 (wrap, R9)
        adv("R7"); chk("R7", 64'(word_addr_o[1:0]), 64'd2, "lin step1");
        adv("R7"); chk("R7", 64'(word_addr_o[1:0]), 64'd3, "lin step2");
        adv("R7"); chk("R7", 64'(word_addr_o[1:0]), 64'd0, "lin step3");
        adv("R9"); chk("R9", 64'(word_addr_o), 64'h2A5C1, "wrap after four");
        // R6: wait holds
        idle_in(); cycle("R6");
        chk("R6", 64'(valid_o), 64'd0, "wait valid");

        // R5: controller write; R8 interleaved from 10 -> 11,00,01
        load(0, 18'h1F0F2, 1, 0, "R5");
        chk("R5", 64'(is_write_o), 64'd1, "cs write");
        adv("R8"); chk("R8", 64'(word_addr_o[1:0]), 64'd3, "ilv step1");
        adv("R8"); chk("R8", 64'(word_addr_o[1:0]), 64'd0, "ilv step2");
        adv("R8"); chk("R8", 64'(word_addr_o[1:0]), 64'd1, "ilv step3");
        chk("R9", 64'(word_addr_o[ADDR_W-1:2]), 64'(18'h1F0F2 >> 2), "upper held");

        // R4: both strobes -> read
        idle_in(); ce_gate_n = 0; ps_n = 0; cs_n = 0; wr_n = 0; addr_i = 18'h00333;
        cycle("R4");
        chk("R4", 64'(is_write_o), 64'd0, "ps priority");
        // R4: gated processor strobe ignored
        idle_in(); ce_gate_n = 1; ps_n = 0; addr_i = 18'h3FFFF; cycle("R4");
        chk("R4", 64'(valid_o), 64'd0, "gated ps valid");
        // R2: missing enable deselects
        idle_in(); ce_gate_n = 0; ce_hi = 0; cs_n = 0; addr_i = 18'h01234; cycle("R2");
        chk("R2", 64'(valid_o), 64'd0, "ce_hi low load");
        // R11: advance deselected
        adv("R11"); chk("R11", 64'(valid_o), 64'd0, "adv deselected");

        // R10: snooze blocks a load
        load(0, 18'h00100, 0, 1, "R5");
        idle_in(); snooze_i = 1; cs_n = 0; ce_gate_n = 0; cycle("R10");
        chk("R10", 64'(standby_o), 64'd1, "standby");
        idle_in(); adv_n = 0; cycle("R10");
        chk("R10", 64'(standby_o), 64'd0, "standby exit");

        // R12: reset mid-burst
        load(1, 18'h00007, 1, 1, "R3");
        adv("R8");
        idle_in(); rst = 1; adv_n = 0; cs_n = 0; cycle("R12");
        chk("R12", 64'(word_addr_o), 64'd0, "reset addr");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            idle_in();
            r = $urandom_range(0, 99);
            rst          = (r < 2);
            snooze_i     = ($urandom_range(0, 99) < 6);
            ce_gate_n    = ($urandom_range(0, 99) < 25);
            ce_lo_n      = ($urandom_range(0, 99) < 10);
            ce_hi        = ($urandom_range(0, 99) >= 10);
            ps_n         = ($urandom_range(0, 99) >= 12);
            cs_n         = ($urandom_range(0, 99) >= 12);
            adv_n        = ($urandom_range(0, 99) < 30);
            wr_n         = 1'($urandom);
            burst_mode_i = 1'($urandom);
            addr_i       = ADDR_W'($urandom);
            cycle("");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule